// File: doc/BRIEF.md
# Filtered Quadrature Front End for One Axis

This block conditions the two phase inputs of one encoder axis before they reach a position counter. A programmable prescaler divides the system clock into a sampling enable; each phase input is synchronised, then accepted only after it has held the same level for three consecutive enabled samples. The accepted pair is decoded into single-clock count pulses, each with a direction bit, at one, two or four counts per full encoder cycle. A change of both phases between two accepted samples cannot be decoded. It raises a sticky error bit and produces no count.

An index input with programmable active level is synchronised and reported as a live status level. When index handling is enabled in a quadrature mode, the first count pulse of each index activation is marked with an index pulse. The counter uses that pulse to reset or load itself. In the plain clock-and-direction mode, the filter and the phase decoder are bypassed. Each rising edge of A is a count, and B selects the direction. A gate input suppresses all counting.

Top module: `qdec_axis`

## Requirements
- R1: The sampling enable fires once every n+1 clocks, where n is the 8-bit value taken from `psc_value` when `psc_load` is high; after reset n = 0.
- R2: A phase level is accepted only after three consecutive enabled samples of the synchronised input agree. At n = 0, a change held long enough gives its count pulse in the 6th clock edge after the change. A level shorter than three sampling periods produces no count.
- R3: With `res_sel` = 3 (x4), every accepted single-phase change counts. With {A,B} written as a 2-bit value, the up order is 00, 10, 11, 01, 00 (A leads B). The reverse order counts down. `cnt_up` = 1 means up.
- R4: With `res_sel` = 2 (x2), only accepted changes of A count, giving two counts per cycle in either direction.
- R5: With `res_sel` = 1 (x1), only an A change while B is low counts: 00 to 10 is up and 10 to 00 is down, giving one count per cycle.
- R6: In a quadrature mode, both phases changing between two accepted samples sets `err_flag` and gives no count. The flag stays set until `err_clr` is high, and a new error in that same cycle wins.
- R7: With `res_sel` = 0 (plain), each rising edge of the synchronised A gives one count pulse, with direction equal to the synchronised B; the filter is bypassed and `err_flag` never sets.
- R8: While `ab_en` is low, no count pulse is produced and no error is recorded. The phase history keeps tracking, so re-enabling causes no stale count.
- R9: `idx_level` is the synchronised index at its active level (`idx_pol` = 1 active high, 0 active low). With `idx_en` high in a quadrature mode, `idx_pulse` accompanies only the first count pulse of each index activation. There is none in plain mode or with `idx_en` low.
- R10: Every count pulse lasts exactly one clock when successive counts are spread out.
- R11: After reset, `cnt_pulse`, `cnt_up`, `idx_pulse` and `err_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psc_load | input | 1 | Load prescaler divisor from psc_value |
| psc_value | input | 8 | Prescaler divisor n (period n+1) |
| res_sel | input | 2 | 0 plain, 1 x1, 2 x2, 3 x4 |
| ab_en | input | 1 | Count gate for the phase inputs |
| in_a | input | 1 | Phase A (count strobe in plain mode) |
| in_b | input | 1 | Phase B (direction in plain mode) |
| idx_in | input | 1 | Index input |
| idx_en | input | 1 | Enable synchronous index marking |
| idx_pol | input | 1 | Index active level |
| err_clr | input | 1 | Clear the error flag |
| cnt_pulse | output | 1 | One-clock count pulse |
| cnt_up | output | 1 | Direction of the last count, 1 = up |
| idx_pulse | output | 1 | Index marker on a count pulse |
| idx_level | output | 1 | Index status level |
| err_flag | output | 1 | Sticky decode error |

## Verification
The bench keeps the default 8-bit prescaler and three-sample filter. It reprograms the divisor to 0, 1 and 3 at run time. With those divisors it can sweep every resolution in both directions, over whole encoder cycles, for each divisor. Small divisors keep each sweep short enough to put the filter's acceptance edge within reach. At each divisor, a pulse two samples long is rejected and one three samples long is accepted. The exact six-edge latency is also checked. The bench computes the expected counts as cycles times counts per cycle.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef enum logic [1:0] {
    RES_PLAIN = 2'd0,
    RES_X1    = 2'd1,
    RES_X2    = 2'd2,
    RES_X4    = 2'd3
  } qres_e;

  // next {A,B} state in the up direction: 00 -> 10 -> 11 -> 01 -> 00
  function automatic logic [1:0] step_up(input logic [1:0] ab);
    case (ab)
      2'b00:   step_up = 2'b10;
      2'b10:   step_up = 2'b11;
      2'b11:   step_up = 2'b01;
      default: step_up = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else if (s == 0) chain_q[s] <= d;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/qdec_prescaler.sv
module qdec_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         tick
);
  logic [W-1:0] div_q, div_n;
  logic [W-1:0] cnt_q, cnt_n;

  assign tick = (cnt_q == div_q);

  always_comb begin
    div_n = div_q;
    cnt_n = cnt_q;
    if (load) begin
      div_n = value;
      cnt_n = '0;
    end else if (tick) begin
      cnt_n = '0;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_n;
      cnt_q <= cnt_n;
    end
  end

  // a divisor above zero never gives two enables in a row
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_q != '0 && !load) |=> !tick);
endmodule

// File: rtl/qdec_filter.sv
module qdec_filter #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  output logic level
);
  localparam int HW = DEPTH - 1;

  logic [HW-1:0]    hist_q, hist_n;
  logic [DEPTH-1:0] window;
  logic             level_q, level_n;
  logic             agree;

  assign window = {hist_q, din};
  assign agree  = (&window) | (~|window);

  always_comb begin
    hist_n  = hist_q;
    level_n = level_q;
    if (tick) begin
      hist_n = window[HW-1:0];
      if (agree) level_n = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      level_q <= 1'b0;
    end else begin
      hist_q  <= hist_n;
      level_q <= level_n;
    end
  end

  assign level = level_q;

  assert_level_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(level_q));
endmodule

// File: rtl/qdec_decoder.sv
module qdec_decoder
  import qdec_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  qres_e res,
  input  logic  ab_en,
  input  logic  acc_a,
  input  logic  acc_b,
  input  logic  raw_a,
  input  logic  raw_b,
  input  logic  idx_act,
  input  logic  idx_en,
  input  logic  err_clr,
  output logic  cnt_pulse,
  output logic  cnt_up,
  output logic  idx_pulse,
  output logic  err_flag
);
  logic [1:0] prev_q, prev_n;
  logic [1:0] now_ab, diff;
  logic       a_last_q;
  logic       pulse_q, pulse_n, up_q, up_n;
  logic       err_q, err_n, idx_q, idx_n, armed_q, armed_n;
  logic       quad, single, both, qual, dir_q, rise, ev, fire, err_set;

  assign now_ab = {acc_a, acc_b};
  assign diff   = now_ab ^ prev_q;
  assign single = ^diff;
  assign both   = &diff;
  assign quad   = (res != RES_PLAIN);
  assign dir_q  = (now_ab == step_up(prev_q));
  assign rise   = raw_a & ~a_last_q;

  always_comb begin
    case (res)
      RES_X4:  qual = single;
      RES_X2:  qual = single & diff[1];
      RES_X1:  qual = single & diff[1] & ~prev_q[0] & ~now_ab[0];
      default: qual = 1'b0;
    endcase
  end

  assign ev      = ab_en & (quad ? (tick & qual) : rise);
  assign err_set = ab_en & quad & tick & both;
  assign fire    = ev & quad & idx_en & idx_act & armed_q;

  always_comb begin
    prev_n  = tick ? now_ab : prev_q;
    pulse_n = ev;
    up_n    = up_q;
    if (ev) up_n = quad ? dir_q : raw_b;
    err_n   = err_set | (err_q & ~err_clr);
    idx_n   = fire;
    if (!idx_act) armed_n = 1'b1;
    else if (fire) armed_n = 1'b0;
    else armed_n = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 2'b00;
      a_last_q <= 1'b0;
      pulse_q  <= 1'b0;
      up_q     <= 1'b0;
      err_q    <= 1'b0;
      idx_q    <= 1'b0;
      armed_q  <= 1'b1;
    end else begin
      prev_q   <= prev_n;
      a_last_q <= raw_a;
      pulse_q  <= pulse_n;
      up_q     <= up_n;
      err_q    <= err_n;
      idx_q    <= idx_n;
      armed_q  <= armed_n;
    end
  end

  assign cnt_pulse = pulse_q;
  assign cnt_up    = up_q;
  assign idx_pulse = idx_q;
  assign err_flag  = err_q;

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q);
  assert_gate_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ab_en |=> !pulse_q);
  assert_idx_on_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q |-> pulse_q);
  assert_plain_no_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res == RES_PLAIN && !err_q) |=> !err_q);
endmodule

// File: rtl/qdec_axis.sv
module qdec_axis
  import qdec_pkg::*;
#(
  parameter int PSC_W    = 8,
  parameter int FILT_LEN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psc_load,
  input  logic [PSC_W-1:0] psc_value,
  input  logic [1:0]       res_sel,
  input  logic             ab_en,
  input  logic             in_a,
  input  logic             in_b,
  input  logic             idx_in,
  input  logic             idx_en,
  input  logic             idx_pol,
  input  logic             err_clr,
  output logic             cnt_pulse,
  output logic             cnt_up,
  output logic             idx_pulse,
  output logic             idx_level,
  output logic             err_flag
);
  localparam int NPH = 2;

  logic [2:0]     sync_v;
  logic [NPH-1:0] acc;
  logic           tick;
  logic           idx_act;

  qdec_sync #(.W(3), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({idx_in, in_b, in_a}), .q(sync_v)
  );

  qdec_prescaler #(.W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .load(psc_load), .value(psc_value), .tick(tick)
  );

  generate
    for (genvar p = 0; p < NPH; p++) begin : g_phase
      qdec_filter #(.DEPTH(FILT_LEN)) u_filt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .din(sync_v[p]), .level(acc[p])
      );
    end
  endgenerate

  assign idx_act   = ~(sync_v[2] ^ idx_pol);
  assign idx_level = idx_act;

  qdec_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .tick(tick), .res(qres_e'(res_sel)),
    .ab_en(ab_en), .acc_a(acc[0]), .acc_b(acc[1]),
    .raw_a(sync_v[0]), .raw_b(sync_v[1]), .idx_act(idx_act),
    .idx_en(idx_en), .err_clr(err_clr),
    .cnt_pulse(cnt_pulse), .cnt_up(cnt_up), .idx_pulse(idx_pulse),
    .err_flag(err_flag)
  );
endmodule

// File: tb/qdec_axis_tb.sv
module qdec_axis_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic psc_load, ab_en, in_a, in_b, idx_in, idx_en, idx_pol, err_clr;
  logic [7:0] psc_value;
  logic [1:0] res_sel;
  logic cnt_pulse, cnt_up, idx_pulse, idx_level, err_flag;

  int n_chk = 0, n_err = 0;
  int n_up = 0, n_dn = 0, n_idx = 0, n_orphan = 0, n_wide = 0;
  logic last_pulse = 1'b0;
  bit done = 0;
  int cur_n = 0;

  always #4 clk = ~clk;

  qdec_axis dut_i (
    .clk(clk), .rst_n(rst_n), .psc_load(psc_load), .psc_value(psc_value),
    .res_sel(res_sel), .ab_en(ab_en), .in_a(in_a), .in_b(in_b),
    .idx_in(idx_in), .idx_en(idx_en), .idx_pol(idx_pol), .err_clr(err_clr),
    .cnt_pulse(cnt_pulse), .cnt_up(cnt_up), .idx_pulse(idx_pulse),
    .idx_level(idx_level), .err_flag(err_flag)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (cnt_pulse) begin
        if (cnt_up) n_up++; else n_dn++;
        if (last_pulse) n_wide++;
      end
      if (idx_pulse) begin
        n_idx++;
        if (!cnt_pulse) n_orphan++;
      end
      last_pulse = cnt_pulse;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic set_psc(input int n);
    psc_value = 8'(n);
    psc_load  = 1'b1;
    wait_clk(1);
    psc_load  = 1'b0;
    cur_n     = n;
    wait_clk(4);
  endtask

  task automatic drive_ab(input logic [1:0] ab, input int hold);
    in_a = ab[1];
    in_b = ab[0];
    wait_clk(hold);
  endtask

  task automatic run_cycles(input bit up, input int cyc);
    int hold;
    hold = 8 * (cur_n + 1) + 4;
    for (int c = 0; c < cyc; c++) begin
      if (up) begin
        drive_ab(2'b10, hold); drive_ab(2'b11, hold);
        drive_ab(2'b01, hold); drive_ab(2'b00, hold);
      end else begin
        drive_ab(2'b01, hold); drive_ab(2'b11, hold);
        drive_ab(2'b10, hold); drive_ab(2'b00, hold);
      end
    end
    wait_clk(16 * (cur_n + 1));
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int bu, bd, bi, exp, per;
    logic [6:0] seen;
    rst_n = 1'b0; psc_load = 0; psc_value = 0; res_sel = 2'd3; ab_en = 1;
    in_a = 0; in_b = 0; idx_in = 0; idx_en = 0; idx_pol = 1; err_clr = 0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    // R11: reset state
    chk(cnt_pulse == 0 && cnt_up == 0 && idx_pulse == 0 && err_flag == 0, "R11",
        {cnt_pulse, cnt_up, idx_pulse, err_flag}, 0);

    // R2: latency at n = 0, pulse on the 6th edge, one clock wide
    bu = n_up;
    in_a = 1'b1;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      seen[i] = cnt_pulse;
    end
    chk(seen == 7'b0100000, "R2 latency", seen, 7'b0100000);
    chk(n_up - bu == 1, "R2 direction", n_up - bu, 1);
    in_a = 1'b0;
    wait_clk(20);

    // R1/R2: filter acceptance edge at several divisors
    for (int k = 0; k < 3; k++) begin
      per = (k == 0) ? 0 : (k == 1) ? 1 : 3;
      set_psc(per);
      bu = n_up; bd = n_dn;
      in_a = 1'b1; wait_clk(2 * (per + 1)); in_a = 1'b0;
      wait_clk(20 * (per + 1));
      chk((n_up - bu) + (n_dn - bd) == 0, "R1 short glitch rejected",
          (n_up - bu) + (n_dn - bd), 0);
      bu = n_up; bd = n_dn;
      in_a = 1'b1; wait_clk(3 * (per + 1)); in_a = 1'b0;
      wait_clk(20 * (per + 1));
      chk((n_up - bu) == 1 && (n_dn - bd) == 1, "R2 three-sample accept",
          (n_up - bu) * 10 + (n_dn - bd), 11);
    end

    // R3/R4/R5: sweeps over divisor, resolution, direction
    for (int k = 0; k < 3; k++) begin
      per = (k == 0) ? 0 : (k == 1) ? 1 : 3;
      set_psc(per);
      for (int r = 1; r <= 3; r++) begin
        res_sel = 2'(r);
        wait_clk(4);
        for (int d = 0; d < 2; d++) begin
          bu = n_up; bd = n_dn;
          run_cycles(d == 0, 3);
          exp = 3 * ((r == 3) ? 4 : (r == 2) ? 2 : 1);
          if (d == 0)
            chk(n_up - bu == exp && n_dn == bd,
                (r == 3) ? "R3 up" : (r == 2) ? "R4 up" : "R5 up", n_up - bu, exp);
          else
            chk(n_dn - bd == exp && n_up == bu,
                (r == 3) ? "R3 down" : (r == 2) ? "R4 down" : "R5 down", n_dn - bd, exp);
        end
      end
    end
    chk(err_flag == 0, "R6 no error on clean sweeps", err_flag, 0);

    // R6: both phases change together
    set_psc(0);
    res_sel = 2'd3;
    bu = n_up; bd = n_dn;
    drive_ab(2'b11, 20);
    chk(err_flag == 1, "R6 set", err_flag, 1);
    chk((n_up - bu) + (n_dn - bd) == 0, "R6 no count", (n_up - bu) + (n_dn - bd), 0);
    drive_ab(2'b00, 40);
    chk(err_flag == 1, "R6 sticky", err_flag, 1);
    err_clr = 1'b1; wait_clk(1); err_clr = 1'b0; wait_clk(2);
    chk(err_flag == 0, "R6 clear", err_flag, 0);

    // R7: plain clock and direction
    res_sel = 2'd0;
    in_b = 1'b1; wait_clk(4);
    bu = n_up; bd = n_dn;
    for (int i = 0; i < 5; i++) begin
      in_a = 1'b1; wait_clk(3); in_a = 1'b0; wait_clk(3);
    end
    wait_clk(6);
    chk(n_up - bu == 5 && n_dn == bd, "R7 up", n_up - bu, 5);
    in_b = 1'b0; wait_clk(4);
    bu = n_up; bd = n_dn;
    for (int i = 0; i < 4; i++) begin
      in_a = 1'b1; wait_clk(3); in_a = 1'b0; wait_clk(3);
    end
    wait_clk(6);
    chk(n_dn - bd == 4 && n_up == bu, "R7 down", n_dn - bd, 4);
    in_a = 1; in_b = 1; wait_clk(3); in_a = 0; in_b = 0; wait_clk(20);
    chk(err_flag == 0, "R7 no error", err_flag, 0);

    // R8: gate
    res_sel = 2'd3; wait_clk(10);
    ab_en = 1'b0;
    bu = n_up; bd = n_dn;
    run_cycles(1'b1, 2);
    drive_ab(2'b11, 20); drive_ab(2'b00, 20);
    chk((n_up - bu) + (n_dn - bd) == 0, "R8 gated count", (n_up - bu) + (n_dn - bd), 0);
    chk(err_flag == 0, "R8 gated error", err_flag, 0);
    ab_en = 1'b1; wait_clk(4);
    bu = n_up;
    run_cycles(1'b1, 1);
    chk(n_up - bu == 4, "R8 resume", n_up - bu, 4);

    // R9: index
    idx_en = 1'b1; idx_pol = 1'b1;
    bi = n_idx;
    idx_in = 1'b1; wait_clk(4);
    chk(idx_level == 1, "R9 level high", idx_level, 1);
    run_cycles(1'b1, 2);
    idx_in = 1'b0; wait_clk(4);
    chk(idx_level == 0, "R9 level low", idx_level, 0);
    chk(n_idx - bi == 1, "R9 once per activation", n_idx - bi, 1);
    bi = n_idx;
    idx_in = 1'b1; wait_clk(4);
    run_cycles(1'b0, 1);
    idx_in = 1'b0; wait_clk(4);
    chk(n_idx - bi == 1, "R9 re-armed", n_idx - bi, 1);
    idx_pol = 1'b0; wait_clk(4);
    chk(idx_level == 1, "R9 active low level", idx_level, 1);
    bi = n_idx;
    run_cycles(1'b1, 1);
    chk(n_idx - bi == 1, "R9 active low mark", n_idx - bi, 1);
    idx_pol = 1'b1; wait_clk(4);
    idx_en = 1'b0; idx_in = 1'b1; wait_clk(4);
    bi = n_idx;
    run_cycles(1'b1, 1);
    chk(n_idx - bi == 0, "R9 disabled", n_idx - bi, 0);
    idx_en = 1'b1; res_sel = 2'd0; in_b = 1'b1; wait_clk(4);
    bi = n_idx;
    for (int i = 0; i < 3; i++) begin
      in_a = 1'b1; wait_clk(3); in_a = 1'b0; wait_clk(3);
    end
    wait_clk(6);
    chk(n_idx - bi == 0, "R9 plain mode", n_idx - bi, 0);
    chk(n_orphan == 0, "R9 index without count", n_orphan, 0);

    // R10: pulse width over the whole run
    chk(n_wide == 0, "R10 pulse width", n_wide, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule